// File: doc/BRIEF.md
# Dual-View Aliased Register File

This block is a register file whose single storage array can be addressed in two ways. In the wide view it holds 32 words of 32 bits. In the narrow view the same bits appear as 64 elements of 16 bits. Narrow element n, for n below 32, is the low half of word n. For n of 32 or more it is the high half of word n−32. A narrow write therefore changes exactly one half of one wide word. A wide read issued afterwards sees the new bits in the matching half.

There is one write port and two read ports. Every port carries its own precision select, so an instruction stream can mix wide and narrow accesses from one cycle to the next. The data carries no precision tag. Only the access decides how the bits are grouped. Writes take effect at the clock edge. Reads are combinational, so a read of a location that is being written in the same cycle returns the value from before the write.

Top module: `dvrf_top`

## Requirements
- R1: A synchronous active-low reset clears every storage bit, so every wide and narrow read returns zero afterwards.
- R2: A wide write (precision select 0) replaces all 32 bits of word addr[4:0] in one cycle. In the wide view, address bit 5 is ignored.
- R3: In the narrow view (precision select 1), address bit 5 selects the half: 0 selects bits 15:0 and 1 selects bits 31:16 of word addr[4:0]. Element H32 is therefore the high half of word 0.
- R4: A narrow write stores wr_data[15:0] into its own 16-bit slice only. The other half of the same word keeps its value, and wr_data[31:16] is ignored.
- R5: A wide read in any cycle after a narrow write returns the newly written bits in the matching half of the word.
- R6: A narrow read returns the selected 16-bit slice in bits 15:0, with bits 31:16 driven to zero.
- R7: A read of a location that is being written in the same cycle returns the old contents, in both views and for aliased halves.
- R8: The two read ports are independent. Each port uses its own precision and address in the same cycle.
- R9: While wr_en is low, no storage bit changes, whatever the other write inputs carry.
- R10: No precision is stored with the data. Bits written in one view read back unchanged in the other view.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all writes happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_prec | input | 1 | Write precision: 0 wide, 1 narrow |
| wr_addr | input | 6 | Write address (bit 5 is the half select in the narrow view) |
| wr_data | input | 32 | Write data; in the narrow view only bits 15:0 are used |
| rd0_prec | input | 1 | Read port 0 precision: 0 wide, 1 narrow |
| rd0_addr | input | 6 | Read port 0 address |
| rd0_data | output | 32 | Read port 0 data, combinational |
| rd1_prec | input | 1 | Read port 1 precision: 0 wide, 1 narrow |
| rd1_addr | input | 6 | Read port 1 address |
| rd1_data | output | 32 | Read port 1 data, combinational |

## Verification
Reads are combinational, so a corrupted half, a write that lands in the wrong lane, or a wrong alias mapping shows on a read port as soon as that location is read, in the cycle after the bad write. A write that leaks into the neighbouring half becomes visible only when the wide word is read. For this reason the bench reads most narrow writes back through the wide view, and reads wide writes back through both narrow views. A read that passes through new data during a write shows up at once, because reads are sampled before each write edge.

// File: rtl/dvrf_pkg.sv
// Package dvrf_pkg
// Holds the shared precision encoding and the lane count used by every
// module of the dual-view register file.
package dvrf_pkg;
    typedef enum logic [0:0] {
        PREC_FULL = 1'b0,
        PREC_HALF = 1'b1
    } prec_t;

    localparam int LANES = 2;
endpackage

// File: rtl/dvrf_wr_decode.sv
// Module dvrf_wr_decode
// Turns one write request into a row index, per-lane write enables and
// per-lane write data. A wide write enables both 16-bit lanes. A narrow
// write enables the single lane picked by the top address bit and feeds
// the low data half to that lane.
// Assumes FULL_W = 2*HALF_W and an address one bit wider than the row index.
module dvrf_wr_decode
    import dvrf_pkg::*;
#(
    parameter int FULL_W = 32,
    parameter int NREG   = 32,
    localparam int HALF_W = FULL_W / 2,
    localparam int RW     = $clog2(NREG),
    localparam int AW     = RW + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_prec,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [FULL_W-1:0]               wr_data,
    output logic [RW-1:0]                   wr_row,
    output logic [LANES-1:0]                lane_we,
    output logic [LANES-1:0][HALF_W-1:0]    lane_wdata
);
    // Row index is common to both views.
    assign wr_row = wr_addr[RW-1:0];

    // Lane enables: both lanes for wide, one lane for narrow.
    always_comb begin
        if (!wr_en) begin
            lane_we = '0;
        end else if (wr_prec == PREC_HALF) begin
            lane_we = wr_addr[RW] ? 2'b10 : 2'b01;
        end else begin
            lane_we = 2'b11;
        end
    end

    // Lane data: a narrow write always supplies its low data half.
    always_comb begin
        lane_wdata[0] = wr_data[HALF_W-1:0];
        if (wr_prec == PREC_HALF) begin
            lane_wdata[1] = wr_data[HALF_W-1:0];
        end else begin
            lane_wdata[1] = wr_data[FULL_W-1:HALF_W];
        end
    end

    // R3: a narrow write touches exactly the lane named by the top address bit.
    a_r3_half_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_prec == PREC_HALF) |-> ($onehot(lane_we) && (lane_we[1] == wr_addr[RW])));

    // R2: a wide write enables both lanes, whatever address bit 5 holds.
    a_r2_full_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_prec == PREC_FULL) |-> (lane_we == 2'b11));

    // R9: no lane is enabled without wr_en.
    a_r9_no_enable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (lane_we == '0));
endmodule

// File: rtl/dvrf_lane_bank.sv
// Module dvrf_lane_bank
// Storage for one 16-bit lane across all rows. It has one synchronous write
// port and NRD combinational read ports. A synchronous active-low reset
// clears the lane. Because reads are combinational, a read in the same
// cycle as a write returns the old value.
module dvrf_lane_bank #(
    parameter int HALF_W = 16,
    parameter int NREG   = 32,
    parameter int NRD    = 2,
    localparam int RW    = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [RW-1:0]                wrow,
    input  logic [HALF_W-1:0]            wdata,
    input  logic [NRD-1:0][RW-1:0]       rd_row,
    output logic [NRD-1:0][HALF_W-1:0]   rd_q
);
    logic [NREG-1:0][HALF_W-1:0] mem_q;

    // Storage update: clear on reset, otherwise write the enabled row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (we) begin
            mem_q[wrow] <= wdata;
        end
    end

    // One combinational read mux per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_q[p] = mem_q[rd_row[p]];
    end

    // R4: an enabled write lands in its row in the next cycle.
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(wrow)] == $past(wdata)));

    // R9: with the lane disabled, its storage holds.
    a_r9_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q));

    // R1: the cycle after reset, the lane is all zero.
    a_r1_cleared: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (mem_q == '0));
endmodule

// File: rtl/dvrf_rd_port.sv
// Module dvrf_rd_port
// Assembles one read port's result from the two lane outputs of its row.
// Wide: {high lane, low lane}. Narrow: the lane picked by the top address
// bit, zero-extended. Purely combinational.
module dvrf_rd_port
    import dvrf_pkg::*;
#(
    parameter int FULL_W = 32,
    parameter int NREG   = 32,
    localparam int HALF_W = FULL_W / 2,
    localparam int RW     = $clog2(NREG),
    localparam int AW     = RW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prec,
    input  logic [AW-1:0]       addr,
    input  logic [HALF_W-1:0]   lo_q,
    input  logic [HALF_W-1:0]   hi_q,
    output logic [FULL_W-1:0]   rdata
);
    // Result formatting by precision.
    always_comb begin
        if (prec == PREC_HALF) begin
            rdata = {{HALF_W{1'b0}}, (addr[RW] ? hi_q : lo_q)};
        end else begin
            rdata = {hi_q, lo_q};
        end
    end

    // R6: a narrow result never carries bits in the upper half.
    a_r6_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (prec == PREC_HALF) |-> (rdata[FULL_W-1:HALF_W] == '0));
endmodule

// File: rtl/dvrf_top.sv
// Module dvrf_top
// Dual-view register file: NREG wide words, which also appear as 2*NREG
// narrow elements. It has one write port and two read ports, each with
// its own precision select. The storage is split into two lane banks
// (low and high halves). The narrow view maps element n to lane n/NREG
// of row n%NREG.
// Assumes NREG is a power of two and FULL_W is even.
module dvrf_top
    import dvrf_pkg::*;
#(
    parameter int FULL_W = 32,
    parameter int NREG   = 32,
    localparam int HALF_W = FULL_W / 2,
    localparam int RW     = $clog2(NREG),
    localparam int AW     = RW + 1,
    localparam int NRD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_prec,
    input  logic [AW-1:0]     wr_addr,
    input  logic [FULL_W-1:0] wr_data,
    input  logic              rd0_prec,
    input  logic [AW-1:0]     rd0_addr,
    output logic [FULL_W-1:0] rd0_data,
    input  logic              rd1_prec,
    input  logic [AW-1:0]     rd1_addr,
    output logic [FULL_W-1:0] rd1_data
);
    logic [RW-1:0]                        wr_row;
    logic [LANES-1:0]                     lane_we;
    logic [LANES-1:0][HALF_W-1:0]         lane_wdata;
    logic [NRD-1:0]                       rd_prec;
    logic [NRD-1:0][AW-1:0]               rd_addr;
    logic [NRD-1:0][RW-1:0]               rd_row;
    logic [LANES-1:0][NRD-1:0][HALF_W-1:0] lane_rq;
    logic [NRD-1:0][FULL_W-1:0]           rd_data;

    // Gather the read-port inputs into arrays.
    assign rd_prec = {rd1_prec, rd0_prec};
    assign rd_addr = {rd1_addr, rd0_addr};
    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];

    dvrf_wr_decode #(.FULL_W(FULL_W), .NREG(NREG)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_prec    (wr_prec),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_row     (wr_row),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata)
    );

    // The row index of every read port is shared by both lanes.
    for (genvar p = 0; p < NRD; p++) begin : g_row
        assign rd_row[p] = rd_addr[p][RW-1:0];
    end

    // One bank per 16-bit lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dvrf_lane_bank #(.HALF_W(HALF_W), .NREG(NREG), .NRD(NRD)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (lane_we[l]),
            .wrow   (wr_row),
            .wdata  (lane_wdata[l]),
            .rd_row (rd_row),
            .rd_q   (lane_rq[l])
        );
    end

    // One formatter per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rdp
        dvrf_rd_port #(.FULL_W(FULL_W), .NREG(NREG)) u_rdp (
            .clk   (clk),
            .rst_n (rst_n),
            .prec  (rd_prec[p]),
            .addr  (rd_addr[p]),
            .lo_q  (lane_rq[0][p]),
            .hi_q  (lane_rq[1][p]),
            .rdata (rd_data[p])
        );
    end

    // R5: a narrow high-half write is seen by a wide read of the aliased word next cycle.
    a_r5_alias_high_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_prec == PREC_HALF && wr_addr[RW])
         && rd0_prec == PREC_FULL && rd0_addr[RW-1:0] == $past(wr_addr[RW-1:0]))
        |-> (rd0_data[FULL_W-1:HALF_W] == $past(wr_data[HALF_W-1:0])));

    // R10: a wide write reads back on port 1 as the narrow low element next cycle.
    a_r10_full_to_half: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_prec == PREC_FULL)
         && rd1_prec == PREC_HALF && !rd1_addr[RW] && rd1_addr[RW-1:0] == $past(wr_addr[RW-1:0]))
        |-> (rd1_data == {{HALF_W{1'b0}}, $past(wr_data[HALF_W-1:0])}));
endmodule

// File: tb/dvrf_top_test.sv
module dvrf_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_prec = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd0_prec = 1'b0, rd1_prec = 1'b0;
    logic [5:0]  rd0_addr = '0, rd1_addr = '0;
    logic [31:0] rd0_data, rd1_data;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [32];

    dvrf_top uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_prec(wr_prec), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_prec(rd0_prec), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_prec(rd1_prec), .rd1_addr(rd1_addr), .rd1_data(rd1_data)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] exp_rd(input logic p, input logic [5:0] a);
        if (!p) return model[a[4:0]];
        return a[5] ? {16'h0, model[a[4:0]][31:16]} : {16'h0, model[a[4:0]][15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle. The reads are checked before the edge, so they see old data (R7).
    task automatic step(input logic we, input logic wp, input logic [5:0] wa, input logic [31:0] wd,
                        input logic p0, input logic [5:0] a0, input logic p1, input logic [5:0] a1,
                        input string tag);
        @(negedge clk);
        wr_en = we; wr_prec = wp; wr_addr = wa; wr_data = wd;
        rd0_prec = p0; rd0_addr = a0; rd1_prec = p1; rd1_addr = a1;
        #1;
        chk({tag, " port0"}, rd0_data, exp_rd(p0, a0));
        chk({tag, " port1"}, rd1_data, exp_rd(p1, a1));
        @(posedge clk);
        if (we && rst_n) begin
            if (!wp) model[wa[4:0]] = wd;
            else if (wa[5]) model[wa[4:0]][31:16] = wd[15:0];
            else model[wa[4:0]][15:0] = wd[15:0];
        end
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd91));
        for (int i = 0; i < 32; i++) model[i] = '0;
        // A write attempted during reset must not survive it.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd5; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        // R1: every element reads zero after reset
        for (int i = 0; i < 64; i++)
            step(0, 0, 0, 0, 1, 6'(i), 0, 6'(i % 32), "R1 reset clear");
        // R3 / R5: write H32 and read it back through the wide word 0
        step(1, 1, 6'd32, 32'hDEAD_BEEF, 0, 0, 0, 0, "R7 pre-write");
        step(0, 0, 0, 0, 0, 6'd0, 1, 6'd32, "R3 R5 H32 alias");
        // R4: write H0 with junk in the upper data bits; H32 must survive
        step(1, 1, 6'd0, 32'h1234_5678, 0, 0, 1, 6'd32, "R7 pre-write H0");
        step(0, 0, 0, 0, 0, 6'd0, 1, 6'd32, "R4 other half kept");
        chk("R4 word0 exact", rd0_data, 32'hBEEF_5678);
        // R2: a wide write with address bit 5 set lands in word 3
        step(1, 0, 6'd35, 32'hA5A5_0F0F, 0, 6'd3, 0, 6'd35, "R7 pre-write full");
        step(0, 0, 0, 0, 1, 6'd3, 1, 6'd35, "R2 R10 full then halves");
        chk("R2 word3 low half", rd0_data, 32'h0000_0F0F);
        chk("R10 word3 high half", rd1_data, 32'h0000_A5A5);
        // R7: read during a write to the same storage returns old data, both views
        step(1, 1, 6'd35, 32'h0000_7777, 0, 6'd3, 1, 6'd35, "R7 same-cycle half");
        chk("R7 old high half", rd1_data, 32'h0000_A5A5);
        step(1, 0, 6'd3, 32'h1111_2222, 1, 6'd35, 0, 6'd3, "R7 same-cycle full");
        chk("R7 old word", rd1_data, 32'h7777_0F0F);
        // R9: a disabled write with live data changes nothing
        step(0, 0, 6'd3, 32'hFFFF_FFFF, 0, 6'd3, 1, 6'd3, "R9 idle write");
        step(0, 1, 6'd35, 32'hFFFF_FFFF, 0, 6'd3, 1, 6'd35, "R9 still held");
        chk("R9 word3 unchanged", rd0_data, 32'h1111_2222);
        // R6: the upper bits of a narrow read are zero
        step(1, 0, 6'd31, 32'hCAFE_F00D, 0, 0, 0, 0, "R6 setup");
        step(0, 0, 0, 0, 1, 6'd63, 1, 6'd31, "R6 zero extend");
        chk("R6 high element", rd0_data, 32'h0000_CAFE);
        // R8 R10: random mixed traffic on both read ports
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 3) != 0), 1'($urandom), 6'($urandom), $urandom,
                 1'($urandom), 6'($urandom), 1'($urandom), 6'($urandom), "R8 R10 random");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule